// File: doc/BRIEF.md
# Pairwise Differential Bit Codec for Offset QPSK

This block removes the carrier phase ambiguity of an offset QPSK link, and the uncertainty over which branch is the in-phase one, by differentially coding the bit stream in pairs. Bits are numbered from 1 in each stream. Coded bits 2k-1 and 2k together select symbol k. The first (odd) bit and the second (even) bit of each pair follow different rules. An odd bit is combined with the complement of the previous coded bit. An even bit is combined with the previous coded bit itself.

The encoder side takes data bits with a valid strobe and emits coded bits. The decoder side takes estimated coded bits and emits recovered data bits. Each side keeps one bit of history (the previous coded bit) and a pair-parity flag. Neither side has backpressure, and each output arrives one cycle after its input. A single clear pulse restarts both sides. A clear makes the next accepted bit the first bit of a new stream and returns the stored history to zero.

Top module: `pair_diff_codec`

## Requirements
- R1: Encoder, odd position (1st, 3rd, 5th ... accepted bit of a stream): the coded bit is the data bit XOR the complement of the previous coded bit.
- R2: Encoder, even position: the coded bit is the data bit XOR the previous coded bit, which is the coded bit of the odd position just before it.
- R3: Decoder: at an odd position the data bit is the coded bit XOR the complement of the previous coded input bit. At an even position it is the coded bit XOR the previous coded input bit.
- R4: The position parity advances only on accepted bits (valid high). Idle cycles change neither the parity nor the history.
- R5: After reset and after a clear, the stored previous coded bit is 0. The first bit after either one therefore comes out inverted, on both sides.
- R6: A clear pulse restarts both sides at an odd position. If a bit is accepted in the same cycle as the clear, that bit is treated as the first bit of the new stream.
- R7: Each output valid is its input valid delayed by exactly one cycle. The output bit holds its value in cycles with no accepted input.
- R8: Feeding the encoder output into the decoder returns the original data bits.
- R9: If the coded stream is inverted before the decoder, the decoder still returns the data bits, except that the first bit after a restart comes out inverted.
- R10: While reset is asserted, both output valids and both output bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Restart both streams at an odd position with zero history |
| encValid | input | 1 | Encoder input bit valid |
| encBit | input | 1 | Encoder data bit |
| encOutValid | output | 1 | Encoder coded bit valid |
| encOutBit | output | 1 | Encoder coded bit |
| decValid | input | 1 | Decoder input bit valid |
| decBit | input | 1 | Decoder coded bit estimate |
| decOutValid | output | 1 | Decoder data bit valid |
| decOutBit | output | 1 | Decoder recovered data bit |

## Verification
The bench goes after four corner cases:
- Idle gaps in the middle of a pair. A design that advanced its parity on every clock would swap the odd and even rules after a gap and corrupt every later bit.
- A clear that arrives in the same cycle as a bit. A design that gave that bit the old parity or history would mis-code the first bit of the new stream.
- An encoder looped into a decoder, with and without an inverted coded stream. A design that complemented the wrong position would fail the round trip, or would fail to recover after the inversion.
- The first bit after a restart. A history that does not return to zero shows up as a wrong first coded bit.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // Strobes from control to one datapath lane
  typedef struct packed {
    logic accept;   // a bit is taken this cycle
    logic oddPos;   // the bit taken is at an odd position
    logic restart;  // history returns to its start value
  } laneStrobes_t;

  localparam int NUM_LANES = 2;  // lane 0 encodes, lane 1 decodes
endpackage

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         inValid [NUM_LANES],
  output laneStrobes_t stb     [NUM_LANES]
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : gParity
    logic oddQ;  // next accepted bit is at an odd position
    logic oddNow;

    assign oddNow = clear | oddQ;
    assign stb[g].accept  = inValid[g];
    assign stb[g].oddPos  = oddNow;
    assign stb[g].restart = clear;

    always_ff @(posedge clk) begin
      if (!rstN)            oddQ <= 1'b1;
      else if (inValid[g])  oddQ <= ~oddNow;
      else if (clear)       oddQ <= 1'b1;
    end
  end
endmodule

// File: rtl/pdc_lane.sv
module pdc_lane
  import pdc_pkg::*;
#(
  parameter bit DECODE     = 1'b0,
  parameter bit HIST_RESET = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  laneStrobes_t stb,
  input  logic         inBit,
  output logic         outValid,
  output logic         outBit
);
  logic histQ;
  logic prevEff;
  logic result;
  logic histNext;

  assign prevEff  = stb.restart ? HIST_RESET : histQ;
  // odd position uses the complement of the previous coded bit
  assign result   = inBit ^ prevEff ^ stb.oddPos;
  // history always holds the coded bit: the output when encoding, the input when decoding
  assign histNext = DECODE ? inBit : result;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ    <= HIST_RESET;
      outValid <= 1'b0;
      outBit   <= 1'b0;
    end else begin
      outValid <= stb.accept;
      if (stb.accept) begin
        outBit <= result;
        histQ  <= histNext;
      end else if (stb.restart) begin
        histQ  <= HIST_RESET;
      end
    end
  end
endmodule

// File: rtl/pair_diff_codec.sv
module pair_diff_codec
  import pdc_pkg::*;
#(
  parameter bit HIST_RESET = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic encValid,
  input  logic encBit,
  output logic encOutValid,
  output logic encOutBit,
  input  logic decValid,
  input  logic decBit,
  output logic decOutValid,
  output logic decOutBit
);
  logic         inValid  [NUM_LANES];
  logic         inBit    [NUM_LANES];
  logic         outValid [NUM_LANES];
  logic         outBit   [NUM_LANES];
  laneStrobes_t stb      [NUM_LANES];

  assign inValid[0] = encValid;
  assign inBit[0]   = encBit;
  assign inValid[1] = decValid;
  assign inBit[1]   = decBit;

  assign encOutValid = outValid[0];
  assign encOutBit   = outBit[0];
  assign decOutValid = outValid[1];
  assign decOutBit   = outBit[1];

  pdc_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (clear),
    .inValid (inValid),
    .stb     (stb)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    pdc_lane #(
      .DECODE     (g == 1),
      .HIST_RESET (HIST_RESET)
    ) uLane (
      .clk      (clk),
      .rstN     (rstN),
      .stb      (stb[g]),
      .inBit    (inBit[g]),
      .outValid (outValid[g]),
      .outBit   (outBit[g])
    );
  end
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker (
  input logic clk,
  input logic rstN,
  input logic clear,
  input logic encValid,
  input logic encBit,
  input logic encOutValid,
  input logic encOutBit,
  input logic decValid,
  input logic decBit,
  input logic decOutValid,
  input logic decOutBit
);
  // R7
  enc_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValid |=> encOutValid);
  // R7
  dec_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> decOutValid);
  // R7
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !encValid |=> (!encOutValid && $stable(encOutBit)));
  // R7
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> (!decOutValid && $stable(decOutBit)));
  // R6
  enc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clear && encValid) |=> (encOutBit == !$past(encBit)));
  // R6
  dec_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clear && decValid) |=> (decOutBit == !$past(decBit)));
endmodule

bind pair_diff_codec pdc_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .clear       (clear),
  .encValid    (encValid),
  .encBit      (encBit),
  .encOutValid (encOutValid),
  .encOutBit   (encOutBit),
  .decValid    (decValid),
  .decBit      (decBit),
  .decOutValid (decOutValid),
  .decOutBit   (decOutBit)
);

// File: tb/tb_pair_diff_codec.sv
module tb_pair_diff_codec;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic encValid = 1'b0, encBit = 1'b0;
  logic decValid = 1'b0, decBit = 1'b0;
  logic encOutValid, encOutBit, decOutValid, decOutBit;

  int checks = 0;
  int errors = 0;
  bit encQ[$];
  bit decQ[$];
  string encTag = "R1";
  string decTag = "R3";
  bit loopMode = 1'b0;
  bit invMode = 1'b0;
  bit firstAfterClr = 1'b0;
  bit finished = 1'b0;

  // bench-side stream state
  bit mEncOdd = 1'b1, mEncPrev = 1'b0;
  bit mDecOdd = 1'b1, mDecPrev = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pair_diff_codec dut (
    .clk(clk), .rstN(rstN), .clear(clear),
    .encValid(encValid), .encBit(encBit),
    .encOutValid(encOutValid), .encOutBit(encOutBit),
    .decValid(decValid), .decBit(decBit),
    .decOutValid(decOutValid), .decOutBit(decOutBit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (encOutValid) begin
        if (encQ.size() == 0) check({encTag, " unexpected enc output"}, 1'b1, 1'b0);
        else check(encTag, encOutBit, encQ.pop_front());
      end
      if (decOutValid) begin
        if (decQ.size() == 0) check({decTag, " unexpected dec output"}, 1'b1, 1'b0);
        else check(decTag, decOutBit, decQ.pop_front());
      end
      if (loopMode) begin
        decValid = encOutValid;
        decBit   = encOutBit ^ invMode;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      encValid = 1'b0; clear = 1'b0;
      if (!loopMode) decValid = 1'b0;
    end
  endtask

  task automatic clearIdle();
    @(negedge clk);
    encValid = 1'b0; clear = 1'b1;
    if (!loopMode) decValid = 1'b0;
    mEncOdd = 1'b1; mEncPrev = 1'b0;
    mDecOdd = 1'b1; mDecPrev = 1'b0;
    firstAfterClr = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  // encoder driver: R1 odd rule, R2 even rule
  task automatic sendEnc(input bit b, input bit clr);
    bit d;
    @(negedge clk);
    if (clr) begin mEncOdd = 1'b1; mEncPrev = 1'b0; end
    d = mEncOdd ? (b ^ ~mEncPrev) : (b ^ mEncPrev);
    mEncPrev = d;
    mEncOdd = ~mEncOdd;
    encQ.push_back(d);
    if (loopMode) begin
      decQ.push_back((invMode && firstAfterClr) ? ~b : b);
      firstAfterClr = 1'b0;
    end
    clear = clr; encValid = 1'b1; encBit = b;
    if (!loopMode) decValid = 1'b0;
  endtask

  // decoder driver: R3
  task automatic sendDec(input bit d);
    bit b;
    @(negedge clk);
    b = mDecOdd ? (d ^ ~mDecPrev) : (d ^ mDecPrev);
    mDecPrev = d;
    mDecOdd = ~mDecOdd;
    decQ.push_back(b);
    clear = 1'b0; encValid = 1'b0; decValid = 1'b1; decBit = d;
  endtask

  task automatic drained(input string tag);
    idle(3);
    check({tag, " enc queue drained"}, encQ.size() == 0, 1'b1);
    check({tag, " dec queue drained"}, decQ.size() == 0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 encOutValid", encOutValid, 1'b0);
    check("R10 encOutBit", encOutBit, 1'b0);
    check("R10 decOutValid", decOutValid, 1'b0);
    check("R10 decOutBit", decOutBit, 1'b0);
    rstN = 1'b1;

    // R5: first bit after reset uses history 0 (b=0 -> d=1)
    encTag = "R5";
    sendEnc(1'b0, 1'b0);
    encTag = "R1 R2";
    sendEnc(1'b0, 1'b0);
    for (int i = 0; i < 40; i++) sendEnc(1'($urandom), 1'b0);
    drained("R1 R2");

    // R4: gaps inside and between pairs must not shift parity
    encTag = "R4";
    for (int i = 0; i < 30; i++) begin
      sendEnc(1'($urandom), 1'b0);
      if (i % 3 == 0) idle(1 + i % 2);
    end
    drained("R4");

    // R6: clear mid-pair with a bit in the same cycle, and clear while idle
    encTag = "R6";
    sendEnc(1'b1, 1'b0);
    sendEnc(1'b0, 1'b1);
    sendEnc(1'b1, 1'b0);
    sendEnc(1'b1, 1'b0);
    clearIdle();
    sendEnc(1'b1, 1'b0);
    sendEnc(1'b0, 1'b0);
    drained("R6");

    // R3: decoder alone on arbitrary coded bits, R5 start from zero history
    clearIdle();
    decTag = "R3";
    for (int i = 0; i < 40; i++) begin
      sendDec(1'($urandom));
      if (i % 7 == 0) idle(1);
    end
    drained("R3");

    // R8: loopback
    clearIdle();
    loopMode = 1'b1;
    encTag = "R8 enc"; decTag = "R8";
    for (int i = 0; i < 50; i++) begin
      sendEnc(1'($urandom), 1'b0);
      if (i % 5 == 0) idle(1);
    end
    drained("R8");

    // R9: inverted coded stream
    clearIdle();
    invMode = 1'b1;
    encTag = "R9 enc"; decTag = "R9";
    for (int i = 0; i < 50; i++) sendEnc(1'($urandom), 1'b0);
    drained("R9");
    loopMode = 1'b0;
    invMode = 1'b0;
    idle(2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule